// File: doc/BRIEF.md
# Set-Bit Position Packer

This block reads a 16-bit mask and returns, in a 64-bit word, the bit numbers of every set bit in the mask. Each bit number takes a 4-bit slot. The lowest set bit goes into slot 0 (bits 3:0), the next higher set bit goes into slot 1, and so on. Slots beyond the last set bit are zero. A crossbar that gathers valid lanes into consecutive destinations can use each slot directly as a mux select.

A 5-bit count of the set bits travels with the word. The count is needed because an empty mask and a mask with only bit 0 set both produce an all-zero word.

The block is a three-stage pipeline. It accepts a new mask on every clock and does not stall. A valid flag travels alongside the data through all three stages.

Top module: `setbit_packer`

## Requirements
- R1: Once `valid_out` is high, slot k of `index_word` (bits 4k+3:4k) holds the bit number of the (k+1)-th lowest set bit of the mask, so filled slots rise strictly. For example, mask 0x0035 gives 0x5420 and mask 0x0A0A gives 0xB931.
- R2: Once `valid_out` is high, every slot whose number is equal to or greater than `set_count` reads zero.
- R3: Once `valid_out` is high, `set_count` equals the number of ones in the mask, from 0 to 16.
- R4: `valid_out` equals `valid_in` as sampled three rising edges earlier. The data outputs belong to that same sample.
- R5: A cycle with `rst` high forces `valid_out` low at the next edge. The block comes out of reset holding no valid entries.
- R6: An all-ones mask yields 0xFEDCBA9876543210 with a count of 16.
- R7: An empty mask and a mask holding only bit 0 both yield an all-zero word. Their counts are 0 and 1 respectively.
- R8: Masks presented on consecutive cycles with `valid_in` high are each returned, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Mask on `mask_in` is valid |
| mask_in | input | 16 | Input mask |
| valid_out | output | 1 | Outputs valid, three cycles after `valid_in` |
| index_word | output | 64 | Packed ascending bit numbers, 4 bits per slot |
| set_count | output | 5 | Number of set bits in the mask |

## Verification
The bench first runs the example masks, both ends of the fill range (empty, bit 0 alone, bit 15 alone, all ones) and a sparse mask. These separate correct ordering from reversed or shifted packing, and show that the count resolves the zero-word ambiguity. It then streams all 65536 masks back to back, which exposes any prefix-count carry fault between the four-bit groups and any hazard between adjacent pipeline entries. Stretches with a random `valid_in`, and a reset in the middle of a stream, show whether the valid flag keeps its three-cycle alignment and is cleared correctly.

// File: rtl/setbit_pack_pkg.sv
package setbit_pack_pkg;

  // bits needed to hold any value from 0 to n
  function automatic int unsigned hold_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sbp_group_count.sv
module sbp_group_count #(
  parameter int GRP_W  = 4,
  parameter int LCNT_W = 3
) (
  input  logic [GRP_W-1:0]        bits,
  output logic [GRP_W*LCNT_W-1:0] local_pre,
  output logic [LCNT_W-1:0]       total
);

  // exclusive running count of ones below each bit of the group
  always_comb begin
    logic [LCNT_W-1:0] run;
    run = '0;
    local_pre = '0;
    for (int i = 0; i < GRP_W; i++) begin
      local_pre[i*LCNT_W +: LCNT_W] = run;
      run = run + LCNT_W'(bits[i]);
    end
    total = run;
  end

endmodule

// File: rtl/sbp_scatter.sv
module sbp_scatter #(
  parameter int MASK_W = 16,
  parameter int GRP_W  = 4,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5,
  parameter int LCNT_W = 3
) (
  input  logic [MASK_W-1:0]               mask,
  input  logic [MASK_W*LCNT_W-1:0]        local_pre,
  input  logic [(MASK_W/GRP_W)*LCNT_W-1:0] grp_total,
  output logic [MASK_W*IDX_W-1:0]         word,
  output logic [CNT_W-1:0]                count
);

  localparam int NGRP = MASK_W / GRP_W;

  logic [CNT_W-1:0] glob_pre [MASK_W];

  // group bases ripple over the few group totals, then add local offsets
  always_comb begin
    logic [CNT_W-1:0] base;
    base = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int j = 0; j < GRP_W; j++) begin
        glob_pre[g*GRP_W+j] = base +
          CNT_W'(local_pre[(g*GRP_W+j)*LCNT_W +: LCNT_W]);
      end
      base = base + CNT_W'(grp_total[g*LCNT_W +: LCNT_W]);
    end
    count = base;
  end

  // each slot ORs in the bit number whose prefix selects it
  genvar k;
  generate
    for (k = 0; k < MASK_W; k++) begin : g_slot
      always_comb begin
        logic [IDX_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < MASK_W; i++) begin
          if (mask[i] && (glob_pre[i] == CNT_W'(k)))
            acc = acc | IDX_W'(i);
        end
        word[k*IDX_W +: IDX_W] = acc;
      end
    end
  endgenerate

endmodule

// File: rtl/setbit_packer.sv
module setbit_packer #(
  parameter int MASK_W = 16,
  parameter int GRP_W  = 4,
  parameter int IDX_W  = $clog2(MASK_W),
  parameter int CNT_W  = setbit_pack_pkg::hold_bits(MASK_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    valid_in,
  input  logic [MASK_W-1:0]       mask_in,
  output logic                    valid_out,
  output logic [MASK_W*IDX_W-1:0] index_word,
  output logic [CNT_W-1:0]        set_count
);

  localparam int NGRP   = MASK_W / GRP_W;
  localparam int LCNT_W = setbit_pack_pkg::hold_bits(GRP_W);

  // stage 1: input capture
  logic              s1_vld;
  logic [MASK_W-1:0] s1_mask;

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= valid_in;
    s1_mask <= mask_in;
  end

  // stage 2: per-group prefix counts
  logic [MASK_W*LCNT_W-1:0] lpre_c;
  logic [NGRP*LCNT_W-1:0]   tot_c;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      sbp_group_count #(.GRP_W(GRP_W), .LCNT_W(LCNT_W)) cnt_i (
        .bits     (s1_mask[g*GRP_W +: GRP_W]),
        .local_pre(lpre_c[g*GRP_W*LCNT_W +: GRP_W*LCNT_W]),
        .total    (tot_c[g*LCNT_W +: LCNT_W])
      );
    end
  endgenerate

  logic                     s2_vld;
  logic [MASK_W-1:0]        s2_mask;
  logic [MASK_W*LCNT_W-1:0] s2_lpre;
  logic [NGRP*LCNT_W-1:0]   s2_tot;

  always_ff @(posedge clk) begin
    if (rst) s2_vld <= 1'b0;
    else     s2_vld <= s1_vld;
    s2_mask <= s1_mask;
    s2_lpre <= lpre_c;
    s2_tot  <= tot_c;
  end

  // stage 3: global prefix, scatter, output register
  logic [MASK_W*IDX_W-1:0] word_c;
  logic [CNT_W-1:0]        cnt_c;

  sbp_scatter #(
    .MASK_W(MASK_W), .GRP_W(GRP_W), .IDX_W(IDX_W),
    .CNT_W(CNT_W), .LCNT_W(LCNT_W)
  ) scat_i (
    .mask     (s2_mask),
    .local_pre(s2_lpre),
    .grp_total(s2_tot),
    .word     (word_c),
    .count    (cnt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) valid_out <= 1'b0;
    else     valid_out <= s2_vld;
    index_word <= word_c;
    set_count  <= cnt_c;
  end

endmodule

// File: rtl/setbit_packer_chk.sv
module setbit_packer_chk #(
  parameter int MASK_W = 16,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    valid_in,
  input logic                    valid_out,
  input logic [MASK_W*IDX_W-1:0] index_word,
  input logic [CNT_W-1:0]        set_count
);

  logic [1:0] since_rst;
  logic       rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)                   since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic asc_ok, tail_ok;
  always_comb begin
    asc_ok  = 1'b1;
    tail_ok = 1'b1;
    for (int k = 0; k < MASK_W; k++) begin
      if (k >= int'(set_count) && index_word[k*IDX_W +: IDX_W] != '0)
        tail_ok = 1'b0;
      if (k >= 1 && k < int'(set_count) &&
          index_word[k*IDX_W +: IDX_W] <= index_word[(k-1)*IDX_W +: IDX_W])
        asc_ok = 1'b0;
    end
  end

  // R1
  ascending_slots_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> asc_ok);
  // R2
  zero_tail_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> tail_ok);
  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> (int'(set_count) <= MASK_W));
  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (valid_out == $past(valid_in, 3)));
  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst_q |-> !valid_out);
  // R7
  empty_word_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_out && set_count == '0) |-> (index_word == '0));

endmodule

bind setbit_packer setbit_packer_chk #(
  .MASK_W(MASK_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .valid_out (valid_out),
  .index_word(index_word),
  .set_count (set_count)
);

// File: tb/setbit_packer_tb_top.sv
`timescale 1ns/1ps
module setbit_packer_tb_top;

  localparam int MW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [15:0] mask_in = '0;
  logic        valid_out;
  logic [63:0] index_word;
  logic [4:0]  set_count;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  setbit_packer dut_i (
    .clk(clk), .rst(rst), .valid_in(valid_in), .mask_in(mask_in),
    .valid_out(valid_out), .index_word(index_word), .set_count(set_count)
  );

  function automatic logic [63:0] ref_word(input logic [15:0] m);
    logic [63:0] w;
    int k;
    w = '0;
    k = 0;
    for (int i = 0; i < MW; i++) begin
      if (m[i]) begin
        w[k*4 +: 4] = 4'(i);
        k++;
      end
    end
    return w;
  endfunction

  function automatic logic [4:0] ref_pop(input logic [15:0] m);
    int c;
    c = 0;
    for (int i = 0; i < MW; i++) c += int'(m[i]);
    return 5'(c);
  endfunction

  // expected pipeline, three entries deep
  logic        hv [3];
  logic [15:0] hm [3];
  string       ht [3];

  initial begin
    for (int i = 0; i < 3; i++) begin
      hv[i] = 1'b0; hm[i] = '0; ht[i] = "R5";
    end
  end

  task automatic check_out();
    checks++;
    if (valid_out !== hv[2]) begin
      fails++;
      $display("FAIL %s/R4: valid_out=%0b expected %0b", ht[2], valid_out, hv[2]);
    end
    if (hv[2]) begin
      checks++;
      if (index_word !== ref_word(hm[2])) begin
        fails++;
        $display("FAIL %s/R1/R2: mask=%h word=%h expected %h",
                 ht[2], hm[2], index_word, ref_word(hm[2]));
      end
      checks++;
      if (set_count !== ref_pop(hm[2])) begin
        fails++;
        $display("FAIL %s/R3: mask=%h count=%0d expected %0d",
                 ht[2], hm[2], set_count, ref_pop(hm[2]));
      end
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [15:0] m,
                      input string t);
    @(negedge clk);
    check_out();
    hv[2] = hv[1]; hm[2] = hm[1]; ht[2] = ht[1];
    hv[1] = hv[0]; hm[1] = hm[0]; ht[1] = ht[0];
    hv[0] = v && !r; hm[0] = m; ht[0] = r ? "R5" : t;
    if (r) begin
      hv[1] = 1'b0; hv[2] = 1'b0;
    end
    rst = r; valid_in = v; mask_in = m;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    // R5: reset held, outputs must stay invalid
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 16'hFFFF, "R5");
    // R1 examples
    step(1'b0, 1'b1, 16'h0035, "R1");
    step(1'b0, 1'b1, 16'h0A0A, "R1");
    step(1'b0, 1'b1, 16'h000E, "R1");
    // R6
    step(1'b0, 1'b1, 16'hFFFF, "R6");
    // R7
    step(1'b0, 1'b1, 16'h0000, "R7");
    step(1'b0, 1'b1, 16'h0001, "R7");
    // R2 edge patterns
    step(1'b0, 1'b1, 16'h8000, "R2");
    step(1'b0, 1'b1, 16'h8001, "R2");
    step(1'b0, 1'b0, 16'h1234, "R4");
    step(1'b0, 1'b1, 16'h5555, "R2");
    // R4: random valid gaps
    for (int i = 0; i < 300; i++)
      step(1'b0, 1'($urandom_range(0, 1)), 16'($urandom), "R4");
    // R8: every mask back to back
    for (int i = 0; i < 65536; i++)
      step(1'b0, 1'b1, 16'(i), "R8");
    // R5: reset in the middle of a full pipeline
    step(1'b1, 1'b1, 16'hABCD, "R5");
    step(1'b0, 1'b1, 16'h0F0F, "R5");
    step(1'b0, 1'b1, 16'hF0F0, "R5");
    // R3: random masks, weighted densities
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] m;
      m = 16'($urandom);
      if (i % 3 == 1) m = m & 16'($urandom);
      if (i % 3 == 2) m = m | 16'($urandom);
      step(1'b0, 1'b1, m, "R3");
    end
    // drain
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, "R4");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule